// File: doc/BRIEF.md
# Ratiometric Complementary Code Generator

This block turns a commanded transducer position and a scaling ratio into a pair of amplitude codes for a three-wire differential position output. Code A grows with position and code B grows with the complement of position. Both are scaled by the same ratio, so their sum stays at the ratio value whatever the position. Downstream logic can therefore recover position as (A-B)/(A+B) independently of the overall amplitude.

Position and ratio arrive together through a valid/ready handshake. After two register stages, a single-cycle strobe presents A and B together. Each code is the upper half of a full-width product, and the low position-width bits of the product are discarded. Between strobes the last pair is held at the outputs.

Top module: `ratio_pair_gen`

## Requirements
- R1: While reset (rst, active high, synchronous) is asserted and on the first cycle after it, outVld is 0 and outA and outB are 0; inRdy is 0 during reset.
- R2: For each accepted input, outA equals floor(inRatio * inPos / 65536), with inPos and inRatio read as unsigned 16-bit values.
- R3: For each accepted input, outB equals floor(inRatio * (65536 - inPos) / 65536); the complement is formed on 17 bits, so inPos = 0 gives outB = inRatio.
- R4: For each result, outA + outB equals inRatio when inRatio * inPos is a multiple of 65536, and inRatio - 1 otherwise.
- R5: With inPos = 0x8000, outA equals outB; with inPos = 0, outA is 0 and outB equals inRatio.
- R6: An input accepted at a rising edge (inVld and inRdy both 1) produces exactly one outVld pulse, one cycle long, two rising edges later, and outA and outB change on that same edge.
- R7: While outVld is 0, outA and outB keep their previous values.
- R8: After reset inRdy rises and stays 1, so a new input is accepted on every cycle and back-to-back inputs give back-to-back results in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inVld | input | 1 | Input word valid |
| inRdy | output | 1 | Block can accept an input |
| inPos | input | 16 | Commanded position, unsigned |
| inRatio | input | 16 | Ratio word that sets the sum A+B |
| outVld | output | 1 | One-cycle strobe marking a new A/B pair |
| outA | output | 16 | Code proportional to position |
| outB | output | 16 | Code proportional to complement of position |

## Verification
A wrong operand or product register shows up as a bad A or B value on the very strobe that carries the affected input, two edges after it was accepted. The sum check catches a one-sided error even when the other code looks plausible. A broken stage-valid bit appears as a missing, doubled or early strobe, or as outputs that drift between strobes; the bench sees this within the next two cycles. Sweeps over spread positions and edge ratios, plus a back-to-back stream, expose any slip of the two channels against each other.

// File: rtl/ratio_pair_pkg.sv
package ratio_pair_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ldOperands;   // capture position, complement and ratio
    logic ldResult;     // capture scaled products
  } stage_ctrl_t;

  localparam int NUM_CH = 2;  // channel 0 = A, channel 1 = B
endpackage

// File: rtl/ratio_scaler.sv
module ratio_scaler #(
  parameter int OP_W    = 17,
  parameter int RATIO_W = 16,
  parameter int SHIFT   = 16
) (
  input  logic [RATIO_W-1:0] ratio,
  input  logic [OP_W-1:0]    operand,
  output logic [RATIO_W-1:0] scaled
);
  localparam int PROD_W = RATIO_W + OP_W;

  logic [PROD_W-1:0] prod;

  assign prod   = PROD_W'(ratio) * PROD_W'(operand);
  // truncating divide by 2^SHIFT; result never exceeds ratio
  assign scaled = RATIO_W'(prod >> SHIFT);
endmodule

// File: rtl/ratio_pair_ctrl.sv
module ratio_pair_ctrl
  import ratio_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inVld,
  output logic        inRdy,
  output stage_ctrl_t ctrl,
  output logic        outVld
);
  logic rdyQ;
  logic stage1Vld;
  logic stage2Vld;
  logic accept;

  assign accept = inVld & rdyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdyQ      <= 1'b0;
      stage1Vld <= 1'b0;
      stage2Vld <= 1'b0;
    end else begin
      rdyQ      <= 1'b1;
      stage1Vld <= accept;
      stage2Vld <= stage1Vld;
    end
  end

  always_comb begin
    ctrl.ldOperands = accept;
    ctrl.ldResult   = stage1Vld;
  end

  assign inRdy  = rdyQ;
  assign outVld = stage2Vld;
endmodule

// File: rtl/ratio_pair_dp.sv
module ratio_pair_dp
  import ratio_pair_pkg::*;
#(
  parameter int POS_W   = 16,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  stage_ctrl_t        ctrl,
  input  logic [POS_W-1:0]   inPos,
  input  logic [RATIO_W-1:0] inRatio,
  output logic [RATIO_W-1:0] resA,
  output logic [RATIO_W-1:0] resB
);
  localparam int OP_W = POS_W + 1;
  localparam logic [OP_W-1:0] FULL_SCALE = OP_W'(1) << POS_W;

  logic [NUM_CH-1:0][OP_W-1:0]    opQ;
  logic [RATIO_W-1:0]             ratioQ;
  logic [NUM_CH-1:0][RATIO_W-1:0] scaledD;
  logic [NUM_CH-1:0][RATIO_W-1:0] resQ;
  logic [NUM_CH-1:0][OP_W-1:0]    opD;

  // channel A uses position, channel B its 17-bit complement
  assign opD[0] = {1'b0, inPos};
  assign opD[1] = FULL_SCALE - {1'b0, inPos};

  always_ff @(posedge clk) begin
    if (rst) begin
      ratioQ <= '0;
    end else if (ctrl.ldOperands) begin
      ratioQ <= inRatio;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ratio_scaler #(
      .OP_W   (OP_W),
      .RATIO_W(RATIO_W),
      .SHIFT  (POS_W)
    ) u_scaler (
      .ratio  (ratioQ),
      .operand(opQ[ch]),
      .scaled (scaledD[ch])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        opQ[ch]  <= '0;
        resQ[ch] <= '0;
      end else begin
        if (ctrl.ldOperands) opQ[ch] <= opD[ch];
        if (ctrl.ldResult)   resQ[ch] <= scaledD[ch];
      end
    end
  end

  assign resA = resQ[0];
  assign resB = resQ[1];
endmodule

// File: rtl/ratio_pair_gen.sv
module ratio_pair_gen
  import ratio_pair_pkg::*;
#(
  parameter int POS_W   = 16,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inVld,
  output logic               inRdy,
  input  logic [POS_W-1:0]   inPos,
  input  logic [RATIO_W-1:0] inRatio,
  output logic               outVld,
  output logic [RATIO_W-1:0] outA,
  output logic [RATIO_W-1:0] outB
);
  stage_ctrl_t ctrl;

  ratio_pair_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .inVld (inVld),
    .inRdy (inRdy),
    .ctrl  (ctrl),
    .outVld(outVld)
  );

  ratio_pair_dp #(
    .POS_W  (POS_W),
    .RATIO_W(RATIO_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .inPos  (inPos),
    .inRatio(inRatio),
    .resA   (outA),
    .resB   (outB)
  );
endmodule

// File: rtl/ratio_pair_chk.sv
module ratio_pair_chk #(
  parameter int POS_W   = 16,
  parameter int RATIO_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               inVld,
  input logic               inRdy,
  input logic [POS_W-1:0]   inPos,
  input logic [RATIO_W-1:0] inRatio,
  input logic               outVld,
  input logic [RATIO_W-1:0] outA,
  input logic [RATIO_W-1:0] outB
);
  localparam logic [POS_W-1:0] HALF_POS = POS_W'(1) << (POS_W - 1);

  logic [RATIO_W:0] sumAB;
  assign sumAB = {1'b0, outA} + {1'b0, outB};

  // R1: reset clears the result and the strobe
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!outVld && outA == '0 && outB == '0));

  // R6: accepted input gives a strobe two edges later
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    (inVld && inRdy) |=> ##1 outVld);

  // R6: no strobe without an input two edges earlier
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    outVld |-> $past(inVld && inRdy, 2));

  // R7: outputs hold between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !outVld |-> ($stable(outA) && $stable(outB)));

  // R4: sum equals ratio or ratio minus one
  a_r4_sum: assert property (@(posedge clk) disable iff (rst)
    outVld |-> (sumAB == {1'b0, $past(inRatio, 2)} ||
                sumAB + 1'b1 == {1'b0, $past(inRatio, 2)}));

  // R5: half-scale gives equal codes
  a_r5_half: assert property (@(posedge clk) disable iff (rst)
    (outVld && $past(inPos, 2) == HALF_POS) |-> outA == outB);

  // R8: ready never drops once raised
  a_r8_ready_stays: assert property (@(posedge clk) disable iff (rst)
    $past(inRdy) |-> inRdy);
endmodule

bind ratio_pair_gen ratio_pair_chk #(
  .POS_W  (POS_W),
  .RATIO_W(RATIO_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .inVld  (inVld),
  .inRdy  (inRdy),
  .inPos  (inPos),
  .inRatio(inRatio),
  .outVld (outVld),
  .outA   (outA),
  .outB   (outB)
);

// File: tb/ratio_pair_gen_bench.sv
`timescale 1ns/1ps
module ratio_pair_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inVld = 1'b0;
  logic        inRdy;
  logic [15:0] inPos = '0;
  logic [15:0] inRatio = '0;
  logic        outVld;
  logic [15:0] outA;
  logic [15:0] outB;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  ratio_pair_gen u_ratio_pair_gen (
    .clk(clk), .rst(rst), .inVld(inVld), .inRdy(inRdy),
    .inPos(inPos), .inRatio(inRatio),
    .outVld(outVld), .outA(outA), .outB(outB)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expA(input longint p, input longint r);
    return (r * p) >> 16;
  endfunction

  function automatic longint expB(input longint p, input longint r);
    return (r * (65536 - p)) >> 16;
  endfunction

  function automatic longint expSum(input longint p, input longint r);
    return (((r * p) % 65536) == 0) ? r : r - 1;
  endfunction

  // check one result pair against the expected codes
  task automatic check_pair(input longint p, input longint r);
    check(outVld == 1'b1, "R6 strobe", outVld, 1);
    check(outA == expA(p, r), "R2 outA", outA, expA(p, r));
    check(outB == expB(p, r), "R3 outB", outB, expB(p, r));
    check(longint'(outA) + longint'(outB) == expSum(p, r), "R4 sum",
          longint'(outA) + longint'(outB), expSum(p, r));
  endtask

  // one isolated transaction: drive, wait two edges, check
  task automatic one_txn(input logic [15:0] p, input logic [15:0] r, input bit holdChk);
    @(negedge clk);
    inVld = 1'b1; inPos = p; inRatio = r;
    @(negedge clk);
    inVld = 1'b0; inPos = ~p; inRatio = ~r;
    check(outVld == 1'b0, "R6 no early strobe", outVld, 0);
    @(negedge clk);
    check_pair(p, r);
    if (holdChk) begin
      @(negedge clk);
      check(outVld == 1'b0, "R6 single pulse", outVld, 0);
      check(outA == expA(p, r), "R7 hold A", outA, expA(p, r));
      check(outB == expB(p, r), "R7 hold B", outB, expB(p, r));
    end
  endtask

  logic [15:0] ratios [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000,
                               16'h1234, 16'hABCD, 16'd1000, 16'h7FFF};
  logic [15:0] sPos [32];
  logic [15:0] sRat [32];

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outVld == 1'b0, "R1 outVld in reset", outVld, 0);
    check(outA == 16'd0 && outB == 16'd0, "R1 outputs in reset", outA, 0);
    check(inRdy == 1'b0, "R1 inRdy in reset", inRdy, 0);
    rst = 1'b0;
    @(negedge clk);
    check(outVld == 1'b0 && outA == 16'd0 && outB == 16'd0, "R1 after reset", outA, 0);
    check(inRdy == 1'b1, "R8 ready after reset", inRdy, 1);

    // R5: end points and half scale
    for (int i = 0; i < 8; i++) begin
      one_txn(16'h0000, ratios[i], 1'b0);
      check(outA == 16'd0, "R5 zero pos A", outA, 0);
      check(outB == ratios[i], "R5 zero pos B", outB, ratios[i]);
      one_txn(16'h8000, ratios[i], 1'b1);
      check(outA == outB, "R5 half pos A==B", outA, outB);
      one_txn(16'hFFFF, ratios[i], 1'b0);
      one_txn(16'h0001, ratios[i], 1'b0);
    end

    // R2 R3 R4: sweep of positions for each ratio
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 65536; p += 251) begin
        one_txn(16'(p), ratios[i], (p % 2008) == 0);
      end
    end

    // R8: back-to-back stream, result i appears at negedge i+2
    for (int i = 0; i < 32; i++) begin
      sPos[i] = 16'(i * 2053 + 7);
      sRat[i] = 16'(16'hF00D - i * 1531);
    end
    for (int c = 0; c < 34; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        check(inRdy == 1'b1, "R8 ready in stream", inRdy, 1);
        check_pair(sPos[c-2], sRat[c-2]);
      end
      if (c < 32) begin
        inVld = 1'b1; inPos = sPos[c]; inRatio = sRat[c];
      end else begin
        inVld = 1'b0;
      end
    end
    @(negedge clk);
    check(outVld == 1'b0, "R8 stream ends", outVld, 0);
    check(outA == expA(sPos[31], sRat[31]), "R7 hold after stream", outA,
          expA(sPos[31], sRat[31]));

    // R7: idle inputs toggling with inVld low change nothing
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      inPos = 16'(k * 999); inRatio = 16'(k * 4441);
      check(outVld == 1'b0, "R7 no strobe while idle", outVld, 0);
      check(outB == expB(sPos[31], sRat[31]), "R7 idle hold B", outB,
            expB(sPos[31], sRat[31]));
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule